// File: doc/BRIEF.md
# Ethernet PHY Management Register Slice

This block holds three 16-bit management registers of a 10/100 Ethernet PHY: a cable-test control and status word, a reset command word and a transmit-clock phase word. A register port reaches them. The port has a 7-bit address, a write strobe, write data and a combinational read path. The register contents and the status inputs that drive it all live in the block's own clock domain.

Each command bit talks to an engine outside the block. The cable-test start bit stays asserted toward the test engine until that engine reports completion. The block then latches the done and fail status. The two reset command bits each produce a single-cycle pulse. One pulse asks for a full device reset, which also returns this slice to its defaults. The other asks for a restart of the circuitry, which leaves the registers as they are.

The phase command bit pulses the clock phase shifter and stores the requested step count, in 4 ns units. A request above ten steps is folded back modulo ten before it is stored. The link-quality code from the receive side appears in the cable-test word only while the link is up.

Top module: `phy_mgmt_regs`

## Requirements
- R1: After reset every register reads 0x0000, and diag_start_o, full_reset_o, restart_o and phase_shift_o are low, with phase_val_o equal to 0.
- R2: A write of 1 to bit 15 of address 0x1E while no test is running sets diag_start_o and bit 15 from the next cycle. It also clears the done bit (bit 1) and the fail bit (bit 0).
- R3: While a test runs, diag_start_o stays high until diag_done_i is sampled high. In the next cycle bit 15 and diag_start_o are 0, bit 1 reads 1, and bit 0 holds the sampled diag_fail_i.
- R4: Writes to address 0x1E while a test runs, including writes of 0 to bit 15, do not change bit 15, bit 1 or bit 0.
- R5: Bits 9:8 of address 0x1E show link_qual_i (01 good, 10 mid, 11 poor) while link_up_i is high, and read 00 while it is low.
- R6: Bits not defined by a register field read 0, and writes to them have no effect. The defined fields are bits 15, 9:8, 1 and 0 at 0x1E, bits 15 and 14 at 0x1F, and bits 4 and 3:0 at 0x42.
- R7: A write of 1 to bit 15 of address 0x1F raises full_reset_o for exactly the next cycle. One cycle later every register of the block and every command output are back at their reset values.
- R8: A write of 1 to bit 14 of address 0x1F raises restart_o for exactly the next cycle and leaves all register contents unchanged.
- R9: A write to address 0x42 stores bits 3:0 as the phase step count, which is driven on phase_val_o. If bit 4 is 1, phase_shift_o is high for exactly the next cycle. Bit 4 reads back 0 once that pulse is over.
- R10: A written step count of 0 to 10 is stored unchanged, and a count of 11 to 15 is stored as the count modulo 10.
- R11: Reads of any address other than 0x1E, 0x1F and 0x42 return 0x0000, and writes to them change no register or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 7 | Register address |
| reg_wr_en | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr, combinational |
| diag_start_o | output | 1 | Cable test request, held while running |
| diag_done_i | input | 1 | Cable test engine finished |
| diag_fail_i | input | 1 | Cable test result failed, valid with diag_done_i |
| link_qual_i | input | 2 | Link quality code from the receive side |
| link_up_i | input | 1 | Link status |
| full_reset_o | output | 1 | One-cycle full device reset request |
| restart_o | output | 1 | One-cycle circuit restart request |
| phase_shift_o | output | 1 | One-cycle transmit clock phase shift request |
| phase_val_o | output | 4 | Stored phase step count, 4 ns units |

## Verification
Several properties are checked on every cycle. The cable-test start bit may only fall after a completion report or a full reset, and it may not fall at all while the engine stays silent. Every command pulse lasts a single cycle. The stored step count never exceeds ten. Masked link quality and zero reads of reserved fields are checked on every cycle as well. Other behaviour only the directed scenarios can show: writes ignored during a running test, the exact folded step values, the restart leaving contents intact, the defaults that follow a full reset, and unmapped addresses having no effect.

// File: rtl/phy_mgmt_pkg.sv
// Shared constants and helpers for the PHY management register slice.
// Assumes a 16-bit data path and 7-bit management addresses.
package phy_mgmt_pkg;
    localparam int DATA_W     = 16;
    localparam int DIAG_ADDR  = 'h1E;
    localparam int RSTC_ADDR  = 'h1F;
    localparam int PHASE_ADDR = 'h42;
    localparam int NUM_REGS   = 3;

    // Index of each register in the decode vector
    typedef enum logic [1:0] {
        SEL_DIAG  = 2'd0,
        SEL_RSTC  = 2'd1,
        SEL_PHASE = 2'd2
    } reg_sel_e;

    // Bit positions that software and neighbours decode
    localparam int DIAG_START_BIT = 15;
    localparam int DIAG_LQ_LO     = 8;
    localparam int DIAG_DONE_BIT  = 1;
    localparam int DIAG_FAIL_BIT  = 0;
    localparam int RST_FULL_BIT   = 15;
    localparam int RST_RESTART_BIT = 14;

    // Fold a requested step count into range: values above max use modulo max
    function automatic int unsigned fold_step(input int unsigned v, input int unsigned max_v);
        return (v > max_v) ? (v % max_v) : v;
    endfunction
endpackage

// File: rtl/diag_reg.sv
// Cable-test control/status register.
// Holds the start request until the external engine reports done, then
// latches done and fail. A new start clears the latched status. Writes
// while running are ignored. Assumes done/fail are synchronous to clk.
module diag_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_clr_i,
    input  logic wr_hit_i,
    input  logic wr_start_i,
    input  logic done_i,
    input  logic fail_i,
    output logic start_o,
    output logic done_o,
    output logic fail_o
);
    logic start_q, done_q, fail_q;

    // Start/done/fail sequencing with the cable test engine
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr_i) begin
            start_q <= 1'b0;
            done_q  <= 1'b0;
            fail_q  <= 1'b0;
        end else if (start_q) begin
            if (done_i) begin
                start_q <= 1'b0;
                done_q  <= 1'b1;
                fail_q  <= fail_i;
            end
        end else if (wr_hit_i && wr_start_i) begin
            start_q <= 1'b1;
            done_q  <= 1'b0;
            fail_q  <= 1'b0;
        end
    end

    assign start_o = start_q;
    assign done_o  = done_q;
    assign fail_o  = fail_q;

    // R3
    start_falls_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(start_q) && !$past(soft_clr_i)) |-> $past(done_i));
    // R4
    start_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_q && !done_i && !soft_clr_i) |=> start_q);
    // R3
    done_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> $past(start_q));
endmodule

// File: rtl/rst_reg.sv
// Reset command register.
// Turns written command bits into single-cycle request pulses. The full
// reset pulse is also used inside the slice to clear every register in
// the following cycle. Assumes writes arrive as one-cycle strobes.
module rst_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_hit_i,
    input  logic wr_full_i,
    input  logic wr_restart_i,
    output logic full_o,
    output logic restart_o
);
    logic full_q, restart_q;

    // Register each command as a pulse; a pending full reset wipes both
    always_ff @(posedge clk) begin
        if (!rst_n || full_q) begin
            full_q    <= 1'b0;
            restart_q <= 1'b0;
        end else begin
            full_q    <= wr_hit_i && wr_full_i;
            restart_q <= wr_hit_i && wr_restart_i;
        end
    end

    assign full_o    = full_q;
    assign restart_o = restart_q;

    // R7
    full_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full_q |=> !full_q);
    // R8
    restart_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart_q |=> !restart_q);
endmodule

// File: rtl/phase_reg.sv
// Transmit clock phase register.
// Stores a step count folded into 0..PHASE_MAX and issues a one-cycle
// shift request when the enable bit is written as 1.
module phase_reg #(
    parameter int PHASE_MAX = 10,
    localparam int PHASE_W  = $clog2(PHASE_MAX + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               soft_clr_i,
    input  logic               wr_hit_i,
    input  logic               wr_en_bit_i,
    input  logic [PHASE_W-1:0] wr_val_i,
    output logic [PHASE_W-1:0] val_o,
    output logic               shift_o
);
    import phy_mgmt_pkg::*;

    logic [PHASE_W-1:0] val_q, val_fold;
    logic               shift_q;

    // Fold out-of-range requests into range
    always_comb begin
        val_fold = PHASE_W'(fold_step(int'(wr_val_i), PHASE_MAX));
    end

    // Capture step count and generate the shift pulse
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr_i) begin
            val_q   <= '0;
            shift_q <= 1'b0;
        end else begin
            shift_q <= wr_hit_i && wr_en_bit_i;
            if (wr_hit_i) val_q <= val_fold;
        end
    end

    assign val_o   = val_q;
    assign shift_o = shift_q;

    // R10
    phase_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        val_q <= PHASE_W'(PHASE_MAX));
    // R9
    shift_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_q |=> !shift_q);
endmodule

// File: rtl/phy_mgmt_regs.sv
// PHY management register slice top.
// Decodes the register port, routes writes to the three register
// submodules and assembles read data. Link quality is masked when the
// link is down. Assumes ADDR_W is wide enough for all register offsets.
module phy_mgmt_regs #(
    parameter int ADDR_W    = 7,
    parameter int PHASE_MAX = 10,
    localparam int DW       = phy_mgmt_pkg::DATA_W,
    localparam int PHASE_W  = $clog2(PHASE_MAX + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_wr_en,
    input  logic [DW-1:0]      reg_wdata,
    output logic [DW-1:0]      reg_rdata,
    output logic               diag_start_o,
    input  logic               diag_done_i,
    input  logic               diag_fail_i,
    input  logic [1:0]         link_qual_i,
    input  logic               link_up_i,
    output logic               full_reset_o,
    output logic               restart_o,
    output logic               phase_shift_o,
    output logic [PHASE_W-1:0] phase_val_o
);
    import phy_mgmt_pkg::*;

    localparam logic [ADDR_W-1:0] REG_ADDRS [NUM_REGS] = '{
        ADDR_W'(DIAG_ADDR), ADDR_W'(RSTC_ADDR), ADDR_W'(PHASE_ADDR)
    };

    logic [NUM_REGS-1:0] sel, wr_hit;
    logic                soft_clr;
    logic                d_start, d_done, d_fail;
    logic                r_full, r_restart;
    logic [1:0]          lq_vis;
    logic [DW-1:0]       diag_word, rst_word, phase_word;
    logic                unused_wdata;

    // One address comparator per register
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_dec
        assign sel[i]    = (reg_addr == REG_ADDRS[i]);
        assign wr_hit[i] = sel[i] && reg_wr_en;
    end

    assign unused_wdata = ^{reg_wdata[13:PHASE_W+1]};

    diag_reg u_diag (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_clr_i (soft_clr),
        .wr_hit_i   (wr_hit[SEL_DIAG]),
        .wr_start_i (reg_wdata[DIAG_START_BIT]),
        .done_i     (diag_done_i),
        .fail_i     (diag_fail_i),
        .start_o    (d_start),
        .done_o     (d_done),
        .fail_o     (d_fail)
    );

    rst_reg u_rst (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_hit_i     (wr_hit[SEL_RSTC]),
        .wr_full_i    (reg_wdata[RST_FULL_BIT]),
        .wr_restart_i (reg_wdata[RST_RESTART_BIT]),
        .full_o       (r_full),
        .restart_o    (r_restart)
    );

    assign soft_clr = r_full;

    phase_reg #(.PHASE_MAX(PHASE_MAX)) u_phase (
        .clk         (clk),
        .rst_n       (rst_n),
        .soft_clr_i  (soft_clr),
        .wr_hit_i    (wr_hit[SEL_PHASE]),
        .wr_en_bit_i (reg_wdata[PHASE_W]),
        .wr_val_i    (reg_wdata[PHASE_W-1:0]),
        .val_o       (phase_val_o),
        .shift_o     (phase_shift_o)
    );

    // Report link quality only while the link is up
    always_comb begin
        lq_vis = link_up_i ? link_qual_i : 2'b00;
    end

    // Assemble each register word; undefined bits stay zero
    always_comb begin
        diag_word = '0;
        diag_word[DIAG_START_BIT]           = d_start;
        diag_word[DIAG_LQ_LO+1:DIAG_LQ_LO]  = lq_vis;
        diag_word[DIAG_DONE_BIT]            = d_done;
        diag_word[DIAG_FAIL_BIT]            = d_fail;
        rst_word = '0;
        rst_word[RST_FULL_BIT]              = r_full;
        rst_word[RST_RESTART_BIT]           = r_restart;
        phase_word = '0;
        phase_word[PHASE_W]                 = phase_shift_o;
        phase_word[PHASE_W-1:0]             = phase_val_o;
    end

    // Read multiplexer; unmapped addresses return zero
    always_comb begin
        reg_rdata = '0;
        if (sel[SEL_DIAG])  reg_rdata = diag_word;
        if (sel[SEL_RSTC])  reg_rdata = rst_word;
        if (sel[SEL_PHASE]) reg_rdata = phase_word;
    end

    assign diag_start_o = d_start;
    assign full_reset_o = r_full;
    assign restart_o    = r_restart;

    // R5
    lq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!link_up_i && sel[SEL_DIAG]) |-> (reg_rdata[DIAG_LQ_LO+1:DIAG_LQ_LO] == 2'b00));
    // R6
    diag_reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel[SEL_DIAG] |-> (reg_rdata[14:10] == '0 && reg_rdata[7:2] == '0));
    // R7
    clear_after_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full_reset_o |=> (!diag_start_o && phase_val_o == '0 && !restart_o));
endmodule

// File: tb/tb_phy_mgmt_regs.sv
// Directed bench for the PHY management register slice.
module tb_phy_mgmt_regs;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [6:0]  addr;
    logic        wr_en;
    logic [15:0] wdata, rdata;
    logic        diag_start, diag_done, diag_fail, link_up;
    logic [1:0]  link_qual;
    logic        full_reset, restart, phase_shift;
    logic [3:0]  phase_val;
    int          checks = 0;
    int          fails  = 0;
    bit          finished = 1'b0;

    always #4 clk = ~clk;

    phy_mgmt_regs dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(addr), .reg_wr_en(wr_en),
        .reg_wdata(wdata), .reg_rdata(rdata), .diag_start_o(diag_start),
        .diag_done_i(diag_done), .diag_fail_i(diag_fail), .link_qual_i(link_qual),
        .link_up_i(link_up), .full_reset_o(full_reset), .restart_o(restart),
        .phase_shift_o(phase_shift), .phase_val_o(phase_val)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [15:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        rd(7'h1E, v); chk("R1 diag", v, 16'h0000);
        rd(7'h1F, v); chk("R1 rstc", v, 16'h0000);
        rd(7'h42, v); chk("R1 phase", v, 16'h0000);
        chk("R1 outputs", {11'd0, diag_start, full_reset, restart, phase_shift, 1'b0}, 16'h0000);
        chk("R1 phase_val", {12'd0, phase_val}, 16'h0000);
    endtask

    task automatic t_diag();
        logic [15:0] v;
        link_up = 1'b1; link_qual = 2'b10;
        wr(7'h1E, 16'h8000);
        chk("R2 start out", {15'd0, diag_start}, 16'h0001);
        rd(7'h1E, v); chk("R2/R5 word", v, 16'h8200);
        wr(7'h1E, 16'h0000);
        rd(7'h1E, v); chk("R4 zero write ignored", v, 16'h8200);
        wr(7'h1E, 16'hFFFF);
        rd(7'h1E, v); chk("R4/R6 ones write ignored", v, 16'h8200);
        repeat (3) step();
        chk("R3 held without done", {15'd0, diag_start}, 16'h0001);
        diag_done = 1'b1; diag_fail = 1'b1;
        step();
        diag_done = 1'b0; diag_fail = 1'b0;
        chk("R3 start cleared", {15'd0, diag_start}, 16'h0000);
        rd(7'h1E, v); chk("R3 done+fail", v, 16'h0203);
        link_qual = 2'b11;
        rd(7'h1E, v); chk("R5 poor", v, 16'h0303);
        wr(7'h1E, 16'h8000);
        rd(7'h1E, v); chk("R2 status cleared", v, 16'h8300);
        link_up = 1'b0;
        rd(7'h1E, v); chk("R5 link down", v, 16'h8000);
        diag_done = 1'b1;
        step();
        diag_done = 1'b0;
        rd(7'h1E, v); chk("R3 pass result", v, 16'h0002);
    endtask

    task automatic t_phase();
        logic [15:0] v;
        wr(7'h42, 16'h0017);
        chk("R9 pulse", {15'd0, phase_shift}, 16'h0001);
        chk("R9 value", {12'd0, phase_val}, 16'h0007);
        step();
        chk("R9 pulse ends", {15'd0, phase_shift}, 16'h0000);
        rd(7'h42, v); chk("R9 readback", v, 16'h0007);
        wr(7'h42, 16'h000D);
        chk("R9 no pulse", {15'd0, phase_shift}, 16'h0000);
        rd(7'h42, v); chk("R10 13->3", v, 16'h0003);
        wr(7'h42, 16'h000A);
        rd(7'h42, v); chk("R10 10 kept", v, 16'h000A);
        wr(7'h42, 16'h000F);
        rd(7'h42, v); chk("R10 15->5", v, 16'h0005);
        wr(7'h42, 16'hFFEB);
        step();
        rd(7'h42, v); chk("R6/R10 reserved ignored", v, 16'h0001);
    endtask

    task automatic t_restart();
        logic [15:0] v;
        wr(7'h42, 16'h0006);
        wr(7'h1E, 16'h8000);
        wr(7'h1F, 16'h4000);
        chk("R8 restart pulse", {14'd0, restart, full_reset}, 16'h0002);
        step();
        chk("R8 pulse ends", {15'd0, restart}, 16'h0000);
        chk("R8 phase kept", {12'd0, phase_val}, 16'h0006);
        rd(7'h1E, v); chk("R8 diag kept", v, 16'h8000);
    endtask

    task automatic t_full();
        logic [15:0] v;
        wr(7'h1F, 16'h8000);
        chk("R7 full pulse", {14'd0, restart, full_reset}, 16'h0001);
        step();
        chk("R7 pulse ends", {15'd0, full_reset}, 16'h0000);
        chk("R7 outputs default", {12'd0, diag_start, 2'b00, phase_shift}, 16'h0000);
        chk("R7 phase default", {12'd0, phase_val}, 16'h0000);
        rd(7'h1E, v); chk("R7 diag default", v, 16'h0000);
        rd(7'h42, v); chk("R7 phase word", v, 16'h0000);
        rd(7'h1F, v); chk("R7 rstc word", v, 16'h0000);
    endtask

    task automatic t_unmapped();
        logic [15:0] v;
        wr(7'h42, 16'h0004);
        wr(7'h5E, 16'hFFFF);
        wr(7'h02, 16'hFFFF);
        wr(7'h7F, 16'hFFFF);
        chk("R11 no pulses", {13'd0, full_reset, restart, phase_shift}, 16'h0000);
        chk("R11 no start", {15'd0, diag_start}, 16'h0000);
        chk("R11 phase kept", {12'd0, phase_val}, 16'h0004);
        rd(7'h5E, v); chk("R11 read 5E", v, 16'h0000);
        rd(7'h00, v); chk("R11 read 00", v, 16'h0000);
    endtask

    initial begin
        rst_n = 1'b0; addr = '0; wr_en = 1'b0; wdata = '0;
        diag_done = 1'b0; diag_fail = 1'b0; link_up = 1'b0; link_qual = 2'b00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        t_reset();
        t_diag();
        t_phase();
        t_restart();
        t_full();
        t_unmapped();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule